// File: doc/BRIEF.md
# Packed 8-bit SIMD add/subtract unit

This block is a combinational execution slice for packed arithmetic on 8-bit lanes held in one integer register. It decodes a 32-bit R-type instruction word. It recognises ten operations: addition and subtraction, each in one of five arithmetic flavours. The flavours are plain wrap-around, signed halving, unsigned halving, signed saturating and unsigned saturating. The block applies the operation to two source register values and presents the destination value in the same cycle.

The register width is a parameter (32 or 64 bits), giving 4 or 8 lanes. Lane i occupies bits 8i+7..8i. A valid output marks a recognised instruction. A sticky saturation flag records that a saturating operation clamped at least one lane, and it holds until an explicit clear. The wrap flavour is built as one full-width add or subtract: the lane MSBs are masked so that no carry crosses a lane boundary, and the true MSBs are then patched back.

Top module: `packed8_addsub`

## Requirements
- R1: The word is recognised only when bits 6..0 equal 1110111, bits 14..12 equal 000 and bits 31..25 (funct7) hold one of the ten codes in R2..R6. In that case valid is 1. Otherwise valid is 0 and result is all zeros. In every code, funct7 bit 0 selects subtract (1) or add (0).
- R2: funct7 0100100 / 0100101 give each lane (a+b) mod 256 / (a-b) mod 256.
- R3: funct7 0000100 / 0000101 treat lanes as signed and give floor((a+b)/2) / floor((a-b)/2).
- R4: funct7 0010100 gives floor((a+b)/2) on unsigned lanes. funct7 0010101 gives the low 8 bits of floor((a-b)/2), with the unsigned difference taken as a signed 9-bit value, so a negative result keeps its sign in the lane MSB.
- R5: funct7 0001100 / 0001101 give the signed sum / difference clamped to -128..127.
- R6: funct7 0011100 / 0011101 give the unsigned sum / difference clamped to 0..255.
- R7: No carry or borrow passes between lanes in any flavour.
- R8: sat_flag is 0 after reset. From the clock edge after a valid saturating operation in which any lane clamped, it reads 1 and stays 1.
- R9: sat_clr high at a clock edge makes sat_flag 0 after that edge. This takes priority over a set in the same cycle.
- R10: Wrap, halving, non-clamping saturating and unrecognised words leave sat_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the saturation flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn | input | 32 | Instruction word |
| src_a | input | XLEN | First source register value |
| src_b | input | XLEN | Second source register value |
| sat_clr | input | 1 | Clears the saturation flag at the next edge |
| result | output | XLEN | Destination value |
| valid | output | 1 | Instruction recognised |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The hardest case to reach is the same-cycle collision between a clamping saturating operation and sat_clr. If the stimulus only clears the flag while idle, a wrong priority stays hidden. The bench therefore first sets the flag, then drives a clamping operation together with the clear, and reads the flag after the edge. Lane independence is driven with patterns in which every lane carries or borrows while its neighbour is zero, so any leak shows up as a nonzero neighbour lane.

// File: rtl/packed8_addsub.sv
`timescale 1ns/1ps
module packed8_addsub #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            sat_clr,
  output logic [XLEN-1:0] result,
  output logic            valid,
  output logic            sat_flag
);
  localparam int LANES = XLEN / 8;
  localparam logic [6:0] OPC = 7'b1110111;
  localparam logic [XLEN-1:0] MSBS = {LANES{8'h80}};

  logic [6:0] f7;
  logic grp, is_sub, m_wrap, m_sh, m_uh, m_ss, m_us;
  logic unused_fields;

  assign f7     = insn[31:25];
  assign grp    = (insn[6:0] == OPC) && (insn[14:12] == 3'b000);
  assign is_sub = f7[0];
  assign m_wrap = grp && (f7[6:1] == 6'b010010);
  assign m_sh   = grp && (f7[6:1] == 6'b000010);
  assign m_uh   = grp && (f7[6:1] == 6'b001010);
  assign m_ss   = grp && (f7[6:1] == 6'b000110);
  assign m_us   = grp && (f7[6:1] == 6'b001110);
  assign valid  = m_wrap | m_sh | m_uh | m_ss | m_us;
  assign unused_fields = ^{insn[24:15], insn[11:7]};

  logic [XLEN-1:0] w_add, w_sub;
  assign w_add = ((src_a & ~MSBS) + (src_b & ~MSBS)) ^ ((src_a ^ src_b) & MSBS);
  assign w_sub = ((src_a | MSBS) - (src_b & ~MSBS)) ^ (~(src_a ^ src_b) & MSBS);

  logic [XLEN-1:0] hs_v, hu_v, ss_v, us_v;
  logic [LANES-1:0] ss_c, us_c;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [8:0] sa, sb, ua, ub, sr, ur;
    assign sa = {src_a[8*i+7], src_a[8*i +: 8]};
    assign sb = {src_b[8*i+7], src_b[8*i +: 8]};
    assign ua = {1'b0, src_a[8*i +: 8]};
    assign ub = {1'b0, src_b[8*i +: 8]};
    assign sr = is_sub ? sa - sb : sa + sb;
    assign ur = is_sub ? ua - ub : ua + ub;
    assign hs_v[8*i +: 8] = sr[8:1];
    assign hu_v[8*i +: 8] = ur[8:1];
    assign ss_c[i] = sr[8] ^ sr[7];
    assign ss_v[8*i +: 8] = ss_c[i] ? (sr[8] ? 8'h80 : 8'h7F) : sr[7:0];
    assign us_c[i] = ur[8];
    assign us_v[8*i +: 8] = us_c[i] ? (is_sub ? 8'h00 : 8'hFF) : ur[7:0];
  end

  always_comb begin
    result = '0;
    if (m_wrap)    result = is_sub ? w_sub : w_add;
    else if (m_sh) result = hs_v;
    else if (m_uh) result = hu_v;
    else if (m_ss) result = ss_v;
    else if (m_us) result = us_v;
  end

  logic clamp;
  assign clamp = (m_ss && |ss_c) || (m_us && |us_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sat_flag <= 1'b0;
    else if (sat_clr) sat_flag <= 1'b0;
    else if (clamp)   sat_flag <= 1'b1;
  end

  // R1
  wrong_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn[6:0] != OPC || insn[14:12] != 3'b000) |-> (!valid && result == '0));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr |=> !sat_flag);
  // R10
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(valid && (m_ss || m_us)));
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_clr && !(m_ss || m_us)) |=> $stable(sat_flag));
  // R7
  wrap_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wrap && !is_sub) |-> (result[7:0] == 8'(src_a[7:0] + src_b[7:0])));
endmodule

// File: tb/packed8_addsub_tb.sv
`timescale 1ns/1ps
module packed8_addsub_tb;
  localparam int XLEN = 64;
  logic clk = 0, rst_n = 0, sat_clr = 0;
  logic [31:0] insn = '0;
  logic [XLEN-1:0] a = '0, b = '0, result;
  logic valid, sat_flag;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  packed8_addsub #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .insn(insn), .src_a(a), .src_b(b),
    .sat_clr(sat_clr), .result(result), .valid(valid), .sat_flag(sat_flag));

  function automatic logic [63:0] model(input logic [6:0] f7, input logic [63:0] x, y,
                                        output logic clamp);
    logic [63:0] r;
    int as, bs, au, bu, v;
    logic sub;
    r = '0; clamp = 0; sub = f7[0];
    for (int i = 0; i < XLEN/8; i++) begin
      as = int'($signed(x[8*i +: 8])); bs = int'($signed(y[8*i +: 8]));
      au = int'(x[8*i +: 8]);          bu = int'(y[8*i +: 8]);
      case (f7[6:1])
        6'b010010: v = sub ? au - bu : au + bu;
        6'b000010: v = (sub ? as - bs : as + bs) >>> 1;
        6'b001010: v = (sub ? au - bu : au + bu) >>> 1;
        6'b000110: begin
          v = sub ? as - bs : as + bs;
          if (v > 127) begin v = 127; clamp = 1; end
          if (v < -128) begin v = -128; clamp = 1; end
        end
        6'b001110: begin
          v = sub ? au - bu : au + bu;
          if (v > 255) begin v = 255; clamp = 1; end
          if (v < 0) begin v = 0; clamp = 1; end
        end
        default: v = 0;
      endcase
      r[8*i +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [6:0] f7);
    return {f7, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1110111};
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_op(input string req, input logic [6:0] f7, input logic [63:0] x, y);
    logic c;
    logic [63:0] e;
    insn = enc(f7); a = x; b = y; #1;
    e = model(f7, x, y, c);
    chk(req, result, e);
    chk(req, {63'd0, valid}, 64'd1);
  endtask

  task automatic test_reset();
    chk("R8 reset flag", {63'd0, sat_flag}, 0);
    chk("R1 reset idle valid", {63'd0, valid}, 0);
    chk("R1 reset idle result", result, 0);
  endtask

  task automatic test_wrap();
    run_op("R2 add", 7'b0100100, 64'h7F80_01FF_4000_C0FE, 64'h0180_FF01_40C0_80FE);
    run_op("R2 sub", 7'b0100101, 64'h7F80_01FF_4000_C0FE, 64'h0180_FF01_40C0_80FE);
    run_op("R2 add mix", 7'b0100100, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic test_lanes();
    insn = enc(7'b0100100); a = 64'h00FF_00FF_00FF_00FF; b = 64'h0001_0001_0001_0001; #1;
    chk("R7 wrap add no carry", result, 64'h0);
    insn = enc(7'b0100101); a = 64'h0000_0000_0000_0000; b = 64'h0001_0001_0001_0001; #1;
    chk("R7 wrap sub no borrow", result, 64'h00FF_00FF_00FF_00FF);
    insn = enc(7'b0011100); a = 64'h00FF_00FF_00FF_00FF; b = 64'h0001_0001_0001_0001; #1;
    chk("R7 usat add lanes", result, 64'h00FF_00FF_00FF_00FF);
    insn = enc(7'b0000100); a = 64'h01FF_01FF_01FF_01FF; b = 64'h0000_0000_0000_0000; #1;
    chk("R7 halving lanes", result, 64'h00FF_00FF_00FF_00FF);
  endtask

  task automatic test_half();
    run_op("R3 sadd half", 7'b0000100, 64'h7F80_FF01_8080_7F7F, 64'h7F80_FE01_7F81_0180);
    run_op("R3 ssub half", 7'b0000101, 64'h7F80_FF01_8080_0003, 64'h807F_01FF_7F01_0004);
    run_op("R4 uadd half", 7'b0010100, 64'hFFFF_0180_7F00_0301, 64'hFF01_0180_8000_0000);
    run_op("R4 usub half", 7'b0010101, 64'h00FF_0103_8000_0000, 64'hFF00_0300_0080_0001);
    insn = enc(7'b0010101); a = 64'h0; b = 64'h0000_0000_0000_00FF; #1;
    chk("R4 usub half 0-255 keeps sign", result, 64'h0000_0000_0000_0080);
  endtask

  task automatic test_sat();
    run_op("R5 ssat add", 7'b0001100, 64'h7F80_4040_0102_C0FF, 64'h0180_4040_0102_C001);
    run_op("R5 ssat sub", 7'b0001101, 64'h7F80_8000_017F_0010, 64'hFF01_7F01_02FF_0020);
    run_op("R6 usat add", 7'b0011100, 64'hFF80_0102_F00F_0000, 64'h0180_0304_1110_0000);
    run_op("R6 usat sub", 7'b0011101, 64'h00FF_0102_F00F_8080, 64'h0101_0201_1110_7F81);
  endtask

  task automatic test_invalid();
    insn = enc(7'b0100100) ^ 32'h0000_0001; a = 64'h0102_0304_0506_0708; b = a; #1;
    chk("R1 bad opcode valid", {63'd0, valid}, 0);
    chk("R1 bad opcode result", result, 0);
    insn = enc(7'b0100100) | 32'h0000_1000; #1;
    chk("R1 bad funct3", {63'd0, valid}, 0);
    insn = enc(7'b0100110); #1;
    chk("R1 bad funct7", {63'd0, valid}, 0);
    chk("R1 bad funct7 result", result, 0);
    insn = enc(7'b1011100); #1;
    chk("R1 bad funct7 high", {63'd0, valid}, 0);
  endtask

  task automatic test_flag();
    insn = '0; sat_clr = 1; step(); sat_clr = 0;
    chk("R9 clear", {63'd0, sat_flag}, 0);
    insn = enc(7'b0100100); a = '1; b = '1; step();
    chk("R10 wrap no set", {63'd0, sat_flag}, 0);
    insn = enc(7'b0000100); step();
    chk("R10 halving no set", {63'd0, sat_flag}, 0);
    insn = enc(7'b0011100) | 32'h0000_2000; step();
    chk("R10 invalid no set", {63'd0, sat_flag}, 0);
    insn = enc(7'b0001100); a = 64'h0101; b = 64'h0101; step();
    chk("R10 no clamp no set", {63'd0, sat_flag}, 0);
    insn = enc(7'b0011101); a = 64'h0; b = 64'h1; step();
    chk("R8 clamp sets", {63'd0, sat_flag}, 1);
    insn = enc(7'b0100101); step();
    chk("R8 sticky across wrap", {63'd0, sat_flag}, 1);
    insn = '0; step();
    chk("R8 sticky idle", {63'd0, sat_flag}, 1);
    insn = enc(7'b0001100); a = 64'h7F; b = 64'h7F; sat_clr = 1; step(); sat_clr = 0;
    chk("R9 clear beats set", {63'd0, sat_flag}, 0);
    step();
    chk("R8 set after clear", {63'd0, sat_flag}, 1);
  endtask

  initial begin
    #3000000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    test_reset();
    rst_n = 1; step();
    test_reset();
    test_wrap();
    test_lanes();
    test_half();
    test_sat();
    test_invalid();
    test_flag();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule